// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal during an automatic station search. A one-cycle start command clears the result and arms a gate window whose length is a whole number of periods of a slow 75 kHz reference clock. While the gate is open, the block counts rising edges of the chosen IF input. The AM-side input is counted edge for edge. The FM-side input first passes through a divide-by-two stage. At the end of the window the block holds a binary count together with a busy flag and an overflow flag. The reader uses these two flags to decide whether the count can be trusted.

All three inputs (reference clock, AM IF, FM IF) are asynchronous to the system clock. Each is synchronized through a flop chain, and only its rising edges are used. The controller is a four-state machine:
- `ST_IDLE`: the state after reset.
- `ST_ALIGN`: entered on start. The block waits here for the first reference edge.
- `ST_GATE`: the window is open. The block leaves this state when the final reference tick of the window arrives.
- `ST_DONE`: the result is held.

A start in any state goes to `ST_ALIGN`, so a start during a measurement restarts it.

Top module: `gated_if_counter`

## Requirements
- R1: After reset, `count_o` is 0, `busy_o` is 0 and `ovf_o` is 0.
- R2: A cycle with `start_i`=1 clears `count_o` and `ovf_o`, captures `gate_sel_i` and `in_sel_i`, and `busy_o` reads 1 from the next cycle.
- R3: After a start, the gate opens on the first synchronized rising edge of `ref_clk_i`. It stays open for exactly REF_BASE·4^g reference periods, where g is the value of `gate_sel_i` (bit 0 is the short-step bit, bit 1 the long-step bit). The factors are 1 for 00, 4 for 01, 16 for 10 and 64 for 11. `busy_o` falls when the gate closes.
- R4: With `in_sel_i`=2'b10, each synchronized rising edge of `if_am_i` inside the gate adds one to the count.
- R5: With `in_sel_i`=2'b01, rising edges of `if_fm_i` are halved first. Only the 2nd, 4th, 6th and later edges after the start are counted.
- R6: With `in_sel_i` at 2'b00 or 2'b11, the gate still runs (busy behaves as in R3) and `count_o` stays 0.
- R7: When an edge arrives while the count is all ones, the count stays all ones and `ovf_o` goes to 1. `ovf_o` stays 1 until the next start.
- R8: While `busy_o`=0, edges on the IF inputs do not change `count_o`. The result is held until the next start.
- R9: A start during an ongoing measurement abandons it and begins a new one from zero.
- R10: Changes on `gate_sel_i` and `in_sel_i` while busy have no effect on the running measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle measurement start |
| gate_sel_i | input | 2 | Gate length code (bit 0 short step, bit 1 long step) |
| in_sel_i | input | 2 | Input select: 2'b10 AM direct, 2'b01 FM halved, others none |
| ref_clk_i | input | 1 | Asynchronous 75 kHz reference clock |
| if_am_i | input | 1 | Asynchronous AM IF input |
| if_fm_i | input | 1 | Asynchronous FM IF input |
| count_o | output | CNT_W | Edge count of the last or current measurement |
| busy_o | output | 1 | 1 while a measurement is in progress |
| ovf_o | output | 1 | 1 when the count saturated |

## Verification
The bench runs every gate code and measures how long busy stays high. An off-by-one in the tick comparison, or a mixed-up code mapping, would show as a window one period too long or a factor of four off. The AM and FM counts are checked against edge totals worked out from the stimulus periods. A prescaler that was missing, or whose phase was not cleared at start, would show as a doubled count or a drift of one. A long window drives the count into saturation, which would reveal a counter that wraps to zero or an overflow flag that clears itself. Further runs restart mid-window, change the codes while busy, and keep toggling the inputs after the gate closes. These would catch a restart that keeps stale counts, codes that are not latched, and counting outside the gate.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_GATE  = 2'd2,
        ST_DONE  = 2'd3
    } ifc_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_AM   = 2'd1,
        SRC_FM   = 2'd2
    } ifc_src_e;

    // in_sel bit 0 is the FM-select bit, bit 1 the AM-select bit
    function automatic ifc_src_e decode_src(input logic [1:0] sel);
        ifc_src_e r;
        case (sel)
            2'b10:   r = SRC_AM;
            2'b01:   r = SRC_FM;
            default: r = SRC_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;

    p_rise_single_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/ifc_halver.sv
module ifc_halver (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic edge_i,
    output logic pulse_o
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      phase_q <= 1'b0;
        else if (clr_i)  phase_q <= 1'b0;
        else if (edge_i) phase_q <= ~phase_q;
    end

    assign pulse_o = edge_i & phase_q;

    // R5: a passed pulse always leaves the halver back in its first phase
    p_half_phase_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && !clr_i) |=> !phase_q);
endmodule

// File: rtl/ifc_gate_fsm.sv
module ifc_gate_fsm
    import ifc_pkg::*;
#(
    parameter int REF_BASE = 75,
    localparam int TICK_W  = $clog2(REF_BASE * 64 + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       tick_i,
    input  logic [1:0] gate_sel_i,
    input  logic [1:0] in_sel_i,
    output logic       gate_open_o,
    output logic       busy_o,
    output ifc_src_e   src_o
);
    ifc_state_e        state_q, state_n;
    logic [TICK_W-1:0] tick_cnt_q;
    logic [TICK_W-1:0] limit_q;
    logic              last_tick;

    assign last_tick = (tick_cnt_q == limit_q - TICK_W'(1));

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  state_n = ST_IDLE;
            ST_ALIGN: if (tick_i) state_n = ST_GATE;
            ST_GATE:  if (tick_i && last_tick) state_n = ST_DONE;
            ST_DONE:  state_n = ST_DONE;
        endcase
        if (start_i) state_n = ST_ALIGN;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // window length and latched selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q    <= '0;
            src_o      <= SRC_NONE;
            tick_cnt_q <= '0;
        end else begin
            if (start_i) begin
                limit_q <= TICK_W'(REF_BASE) << {gate_sel_i, 1'b0};
                src_o   <= decode_src(in_sel_i);
            end
            if (start_i || state_q == ST_ALIGN)
                tick_cnt_q <= '0;
            else if (state_q == ST_GATE && tick_i && !last_tick)
                tick_cnt_q <= tick_cnt_q + TICK_W'(1);
        end
    end

    // outputs
    always_comb begin
        gate_open_o = 1'b0;
        busy_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ALIGN: busy_o = 1'b1;
            ST_GATE:  begin busy_o = 1'b1; gate_open_o = 1'b1; end
            ST_DONE:  ;
        endcase
    end

    p_gate_bound_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATE) |-> (tick_cnt_q < limit_q));
    p_close_on_tick_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATE && !tick_i && !start_i) |=> (state_q == ST_GATE));
endmodule

// File: rtl/ifc_sat_counter.sv
module ifc_sat_counter #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         ovf_o
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_o <= '0;
            ovf_o <= 1'b0;
        end else if (inc_i) begin
            if (&cnt_o) ovf_o <= 1'b1;
            else        cnt_o <= cnt_o + W'(1);
        end
    end

    p_no_overflow_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (&cnt_o));
    p_ovf_sticky_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o);
endmodule

// File: rtl/gated_if_counter.sv
module gated_if_counter
    import ifc_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int REF_BASE    = 75,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       gate_sel_i,
    input  logic [1:0]       in_sel_i,
    input  logic             ref_clk_i,
    input  logic             if_am_i,
    input  logic             if_fm_i,
    output logic [CNT_W-1:0] count_o,
    output logic             busy_o,
    output logic             ovf_o
);
    logic     ref_rise, am_rise, fm_rise, fm_half;
    logic     gate_open, count_ev;
    ifc_src_e src;

    ifc_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ref_clk_i), .rise_o(ref_rise));
    ifc_edge_sync #(.STAGES(SYNC_STAGES)) u_am_sync (
        .clk(clk), .rst_n(rst_n), .async_i(if_am_i), .rise_o(am_rise));
    ifc_edge_sync #(.STAGES(SYNC_STAGES)) u_fm_sync (
        .clk(clk), .rst_n(rst_n), .async_i(if_fm_i), .rise_o(fm_rise));

    ifc_halver u_fm_half (
        .clk(clk), .rst_n(rst_n), .clr_i(start_i),
        .edge_i(fm_rise), .pulse_o(fm_half));

    ifc_gate_fsm #(.REF_BASE(REF_BASE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(ref_rise),
        .gate_sel_i(gate_sel_i), .in_sel_i(in_sel_i),
        .gate_open_o(gate_open), .busy_o(busy_o), .src_o(src));

    always_comb begin
        unique case (src)
            SRC_AM:  count_ev = am_rise;
            SRC_FM:  count_ev = fm_half;
            default: count_ev = 1'b0;
        endcase
    end

    ifc_sat_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(start_i),
        .inc_i(gate_open & count_ev), .cnt_o(count_o), .ovf_o(ovf_o));

    p_start_busy_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && count_o == '0 && !ovf_o));
    p_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(count_o));
    p_none_zero_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_NONE) |-> (count_o == '0));
endmodule

// File: tb/gated_if_counter_tb.sv
module gated_if_counter_tb;
    localparam int CW   = 12;
    localparam int BASE = 75;
    localparam int REFH = 4;

    logic clk = 0, rst_n = 0, start = 0;
    logic [1:0] gsel = 0, isel = 0;
    logic ref_clk = 0, am = 0, fm = 0;
    logic [CW-1:0] count;
    logic busy, ovf;

    int errors = 0, checks = 0, cycles = 0;
    int am_half = 0, fm_half = 0, ref_c = 0, am_c = 0, fm_c = 0;

    gated_if_counter #(.CNT_W(CW), .REF_BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .gate_sel_i(gsel),
        .in_sel_i(isel), .ref_clk_i(ref_clk), .if_am_i(am), .if_fm_i(fm),
        .count_o(count), .busy_o(busy), .ovf_o(ovf));

    always #10 clk = ~clk;

    // stimulus waveforms
    always @(negedge clk) begin
        ref_c++; if (ref_c >= REFH) begin ref_c = 0; ref_clk <= ~ref_clk; end
        if (am_half > 0) begin am_c++; if (am_c >= am_half) begin am_c = 0; am <= ~am; end end
        if (fm_half > 0) begin fm_c++; if (fm_c >= fm_half) begin fm_c = 0; fm <= ~fm; end end
    end

    // behavioural reference: delayed input samples and integer state
    int m_cnt, m_st, m_ticks, m_lim, m_src;
    bit m_ovf, m_ph;
    bit rq[$], aq[$], fq[$];
    function automatic bit rose(ref bit q[$]);
        return q[1] && !q[2];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ovf = 0; m_st = 0; m_ticks = 0; m_lim = 1; m_src = 0; m_ph = 0;
            rq = '{0,0,0}; aq = '{0,0,0}; fq = '{0,0,0};
        end else begin
            bit tk, ae, fe, ev;
            tk = rose(rq); ae = rose(aq); fe = rose(fq);
            ev = (m_src == 1 && ae) || (m_src == 2 && fe && m_ph);
            if (start) begin
                m_st = 1; m_cnt = 0; m_ovf = 0; m_ticks = 0;
                m_lim = BASE * (1 << (2 * gsel));
                m_src = (isel == 2'b10) ? 1 : (isel == 2'b01) ? 2 : 0;
            end else if (m_st == 1) begin
                if (tk) begin m_st = 2; m_ticks = 0; end
            end else if (m_st == 2) begin
                if (ev) begin
                    if (m_cnt == (1 << CW) - 1) m_ovf = 1; else m_cnt++;
                end
                if (tk) begin
                    if (m_ticks == m_lim - 1) m_st = 3; else m_ticks++;
                end
            end
            if (start) m_ph = 0; else if (fe) m_ph = ~m_ph;
            void'(rq.pop_back()); rq.push_front(ref_clk);
            void'(aq.pop_back()); aq.push_front(am);
            void'(fq.pop_back()); fq.push_front(fm);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (rst_n && cycles > 2) begin
            string t;
            t = (m_src == 1) ? "R4 model" : (m_src == 2) ? "R5 model" : "R6 model";
            chk(t, int'(count), m_cnt);
            chk("R3 model busy", int'(busy), int'(m_st == 1 || m_st == 2));
            chk("R7 model ovf", int'(ovf), int'(m_ovf));
        end
    end

    task automatic kick(input logic [1:0] g, input logic [1:0] s);
        @(negedge clk); gsel = g; isel = s; start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (busy) begin @(negedge clk); n++; end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        int n, held;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 count", int'(count), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 ovf", int'(ovf), 0);

        // R4: AM period 6 cycles, 1x gate = 600 cycles -> 100 edges
        am_half = 3; fm_half = 2;
        kick(2'b00, 2'b10);
        chk("R2 busy after start", int'(busy), 1);
        chk("R2 count cleared", int'(count), 0);
        wait_done(n);
        chk_rng("R3 gate 1x length", n, BASE * 8, BASE * 8 + 12);
        chk_rng("R4 AM count", int'(count), 99, 101);

        // R8: inputs keep toggling after the gate closed
        held = int'(count);
        repeat (200) @(negedge clk);
        chk("R8 held count", int'(count), held);
        chk("R8 busy low", int'(busy), 0);

        // R5: FM period 4 cycles -> 150 edges halved -> 75
        kick(2'b00, 2'b01);
        wait_done(n);
        chk_rng("R5 FM halved count", int'(count), 74, 76);

        // R3: 4x and 16x windows with AM
        kick(2'b01, 2'b10);
        wait_done(n);
        chk_rng("R3 gate 4x length", n, BASE * 32, BASE * 32 + 12);
        chk_rng("R4 AM count 4x", int'(count), 399, 401);
        kick(2'b10, 2'b10);
        wait_done(n);
        chk_rng("R3 gate 16x length", n, BASE * 128, BASE * 128 + 12);
        chk_rng("R4 AM count 16x", int'(count), 1599, 1601);

        // R6: no input selected
        kick(2'b00, 2'b00);
        wait_done(n);
        chk_rng("R6 gate runs code 00", n, BASE * 8, BASE * 8 + 12);
        chk("R6 count zero code 00", int'(count), 0);
        kick(2'b00, 2'b11);
        wait_done(n);
        chk("R6 count zero code 11", int'(count), 0);

        // R7: 64x window with AM period 4 -> 9600 edges saturate
        am_half = 2;
        kick(2'b11, 2'b10);
        wait_done(n);
        chk_rng("R3 gate 64x length", n, BASE * 512, BASE * 512 + 12);
        chk("R7 saturated count", int'(count), (1 << CW) - 1);
        chk("R7 overflow set", int'(ovf), 1);
        repeat (50) @(negedge clk);
        chk("R7 overflow sticky", int'(ovf), 1);

        // R2/R9: restart mid-run clears overflow and counts afresh
        am_half = 3;
        kick(2'b00, 2'b10);
        chk("R2 overflow cleared", int'(ovf), 0);
        repeat (300) @(negedge clk);
        kick(2'b00, 2'b10);
        chk("R9 restart count zero", int'(count), 0);
        wait_done(n);
        chk_rng("R9 restart window", n, BASE * 8, BASE * 8 + 12);
        chk_rng("R9 fresh count", int'(count), 99, 101);

        // R10: codes changed while busy are ignored
        kick(2'b00, 2'b10);
        gsel = 2'b11; isel = 2'b01;
        wait_done(n);
        chk_rng("R10 window unchanged", n, BASE * 8, BASE * 8 + 12);
        chk_rng("R10 source unchanged", int'(count), 99, 101);

        repeat (10) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        finish_run();
    end
endmodule